// File: doc/BRIEF.md
# Conditional Branch and Skip Sequencer

This block owns the program counter of an 8-bit processor while one instruction from its branch-and-skip group runs. The fetch logic pulses `start` in the fetch cycle of such an opcode. It supplies the decoded instruction kind, a condition selector and a polarity bit. The sequencer then steps the counter through any second fetch and the execute cycles. It evaluates the selected status input and leaves the counter on the next instruction to fetch.

A short branch reads its target byte through a byte-wide memory read port. When the branch is taken, only the low byte of the counter is replaced, so control stays in the page that holds the target byte. Skips read no memory. The one-byte short skip passes over the following byte. A long skip passes over two bytes only when its condition holds. A one-cycle `done` pulse marks the final execute cycle. The number of cycles the instruction used is kept in `lastCycles`.

Top module: `brskip_seq`

## Requirements
- R1: After reset, `pc` is 0, `busy` and `done` are 0 and `lastCycles` is 0.
- R2: While idle, `pcLoad` copies `pcLoadVal` into `pc` at the next edge, and with neither `pcLoad` nor `start` the counter holds. While `busy`, `pcLoad` and `start` are ignored.
- R3: `kind` encodes 0 = short branch (2 bytes, 2 cycles), 1 = interrupt branch (3 bytes, 3 cycles: two fetches and one execute), 2 = short skip (2 cycles), 3 = long skip (3 cycles). The `start` cycle counts as cycle 1. `lastCycles` holds the count of the last finished instruction.
- R4: `condSel` encodes 0 always, 1 accumulator zero, 2 carry flag, 3 Q, 4..7 external flag 0..3, 8 counter interrupt pending and 9 external interrupt pending (codes 4..9 for branches only), and 10 master interrupt enable (long skips only). Any other code, or a code that is illegal for the kind, evaluates false. `condInv` = 1 inverts the result, so code 0 inverted is the no-branch or no-skip form.
- R5: A taken branch sets `pc` to {high byte of the target-byte address, target byte}, even when the opcode sits at the end of a page.
- R6: A branch that is not taken leaves `pc` at opcode address + 2 (short) or + 3 (interrupt form).
- R7: `memRd` is high only in the single execute cycle of a branch, with `memAddr` equal to the target-byte address (opcode + 1, or opcode + 2 for the interrupt form).
- R8: A short skip leaves `pc` at opcode address + 2.
- R9: A long skip leaves `pc` at opcode + 3 when its condition holds and at opcode + 1 otherwise.
- R10: The condition is sampled once, at the end of the first execute cycle, and a long skip uses that sampled value even if the inputs change later.
- R11: `done` is high for exactly one cycle, the final execute cycle. In that cycle `taken` shows whether the branch or skip happened (1 for the short skip).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Fetch cycle of a group opcode (idle only) |
| kind | input | 2 | Instruction kind, see R3 |
| condSel | input | 4 | Condition selector, see R4 |
| condInv | input | 1 | Inverts the selected condition |
| accZero | input | 1 | Accumulator is zero |
| carryFlag | input | 1 | Carry/borrow flag |
| qFlag | input | 1 | Output flag Q |
| extFlag | input | NUM_EF | External flag inputs |
| mie | input | 1 | Master interrupt enable |
| ctrIrq | input | 1 | Counter interrupt pending |
| extIrq | input | 1 | External interrupt pending |
| pcLoad | input | 1 | Load the counter while idle |
| pcLoadVal | input | PC_W | Value for `pcLoad` |
| memData | input | DATA_W | Byte read at `memAddr`, same cycle |
| memAddr | output | PC_W | Read address (the counter) |
| memRd | output | 1 | Target-byte read strobe |
| pc | output | PC_W | Program counter |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final execute cycle |
| taken | output | 1 | Outcome, valid with `done` |
| lastCycles | output | CNT_W | Cycle count of the last instruction |

## Verification
The outcome of an instruction appears at the ports N-1 cycles after the `start` cycle, where N is 2 or 3 by kind. At that point `done`, `taken` and, for branches, `memRd`/`memAddr` are valid. The new `pc` and `lastCycles` are visible one edge later. The bench drives on falling edges and counts falling edges from `start` until it sees `done`. It checks the count against the expected N. It reads `pc`, `lastCycles` and `busy` at the next falling edge and confirms there that `done` has dropped. The hold test changes the status inputs only after the sampling edge and changes `pcLoad`/`start` only while the block is busy.

// File: rtl/brskip_pkg.sv
package brskip_pkg;

  typedef enum logic [1:0] {
    K_BR_SHORT   = 2'd0,
    K_BR_IRQ     = 2'd1,
    K_SKIP_SHORT = 2'd2,
    K_SKIP_LONG  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH2 = 2'd1,
    ST_EXEC1  = 2'd2,
    ST_EXEC2  = 2'd3
  } state_e;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'd0;
  localparam logic [SEL_W-1:0] SEL_ZERO   = 4'd1;
  localparam logic [SEL_W-1:0] SEL_CARRY  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_Q      = 4'd3;
  localparam logic [SEL_W-1:0] SEL_EF0    = 4'd4;
  localparam logic [SEL_W-1:0] SEL_CTR    = 4'd8;
  localparam logic [SEL_W-1:0] SEL_EXT    = 4'd9;
  localparam logic [SEL_W-1:0] SEL_MIE    = 4'd10;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic extLoad;
    logic loadLow;
    logic step2;
    logic step1;
  } pc_strobe_t;

endpackage

// File: rtl/brskip_cond.sv
module brskip_cond
  import brskip_pkg::*;
#(
  parameter int NUM_EF = 4
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              invert,
  input  logic              forLong,
  input  logic              accZero,
  input  logic              carryFlag,
  input  logic              qFlag,
  input  logic [NUM_EF-1:0] extFlag,
  input  logic              mie,
  input  logic              ctrIrq,
  input  logic              extIrq,
  output logic              condMet
);

  logic [NUM_EF-1:0] efHit;
  logic              raw;

  generate
    for (genvar i = 0; i < NUM_EF; i++) begin : g_ef
      assign efHit[i] = (sel == SEL_W'(int'(SEL_EF0) + i)) & extFlag[i];
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_ALWAYS: raw = 1'b1;
      SEL_ZERO:   raw = accZero;
      SEL_CARRY:  raw = carryFlag;
      SEL_Q:      raw = qFlag;
      SEL_CTR:    raw = !forLong && ctrIrq;
      SEL_EXT:    raw = !forLong && extIrq;
      SEL_MIE:    raw = forLong && mie;
      default:    raw = !forLong && (|efHit);
    endcase
  end

  assign condMet = raw ^ invert;

endmodule

// File: rtl/brskip_ctrl.sv
module brskip_ctrl
  import brskip_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       kind,
  input  logic [SEL_W-1:0] condSel,
  input  logic             condInv,
  input  logic             pcLoad,
  input  logic             condMet,
  output logic [SEL_W-1:0] selHeld,
  output logic             invHeld,
  output logic             longHeld,
  output pc_strobe_t       strobe,
  output logic             memRd,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic [CNT_W-1:0] lastCycles
);

  state_e           state, nextState;
  kind_e            kindR;
  logic             condHeld;
  logic [CNT_W-1:0] cycleCnt;

  assign busy     = (state != ST_IDLE);
  assign longHeld = (kindR == K_SKIP_LONG);

  always_comb begin
    strobe    = '0;
    nextState = state;
    memRd     = 1'b0;
    done      = 1'b0;
    taken     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.step1 = 1'b1;
          nextState    = (kind_e'(kind) == K_BR_IRQ) ? ST_FETCH2 : ST_EXEC1;
        end else if (pcLoad) begin
          strobe.extLoad = 1'b1;
        end
      end
      ST_FETCH2: begin
        strobe.step1 = 1'b1;
        nextState    = ST_EXEC1;
      end
      ST_EXEC1: begin
        case (kindR)
          K_BR_SHORT, K_BR_IRQ: begin
            memRd          = 1'b1;
            done           = 1'b1;
            taken          = condMet;
            strobe.loadLow = condMet;
            strobe.step1   = !condMet;
            nextState      = ST_IDLE;
          end
          K_SKIP_SHORT: begin
            done         = 1'b1;
            taken        = 1'b1;
            strobe.step1 = 1'b1;
            nextState    = ST_IDLE;
          end
          default: nextState = ST_EXEC2;
        endcase
      end
      default: begin
        done         = 1'b1;
        taken        = condHeld;
        strobe.step2 = condHeld;
        nextState    = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kindR      <= K_BR_SHORT;
      selHeld    <= '0;
      invHeld    <= 1'b0;
      condHeld   <= 1'b0;
      cycleCnt   <= '0;
      lastCycles <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        kindR    <= kind_e'(kind);
        selHeld  <= condSel;
        invHeld  <= condInv;
        cycleCnt <= CNT_W'(2);
      end else if (busy) begin
        cycleCnt <= cycleCnt + 1'b1;
      end
      if (state == ST_EXEC1) condHeld <= condMet;
      if (done) lastCycles <= cycleCnt;
    end
  end

endmodule

// File: rtl/brskip_dp.sv
module brskip_dp
  import brskip_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pc_strobe_t        strobe,
  input  logic [PC_W-1:0]   pcLoadVal,
  input  logic [DATA_W-1:0] memData,
  output logic [PC_W-1:0]   pc
);

  localparam int PAGE_W = PC_W - DATA_W;

  logic [PAGE_W-1:0] pageBits;
  assign pageBits = pc[PC_W-1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strobe.extLoad) begin
      pc <= pcLoadVal;
    end else if (strobe.loadLow) begin
      pc <= {pageBits, memData};
    end else if (strobe.step2) begin
      pc <= pc + PC_W'(2);
    end else if (strobe.step1) begin
      pc <= pc + PC_W'(1);
    end
  end

endmodule

// File: rtl/brskip_seq.sv
module brskip_seq
  import brskip_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int NUM_EF = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic [3:0]        condSel,
  input  logic              condInv,
  input  logic              accZero,
  input  logic              carryFlag,
  input  logic              qFlag,
  input  logic [NUM_EF-1:0] extFlag,
  input  logic              mie,
  input  logic              ctrIrq,
  input  logic              extIrq,
  input  logic              pcLoad,
  input  logic [PC_W-1:0]   pcLoadVal,
  input  logic [DATA_W-1:0] memData,
  output logic [PC_W-1:0]   memAddr,
  output logic              memRd,
  output logic [PC_W-1:0]   pc,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [CNT_W-1:0]  lastCycles
);

  pc_strobe_t       strobe;
  logic [SEL_W-1:0] selHeld;
  logic             invHeld;
  logic             longHeld;
  logic             condMet;

  brskip_cond #(.NUM_EF(NUM_EF)) u_cond (
    .sel(selHeld), .invert(invHeld), .forLong(longHeld),
    .accZero(accZero), .carryFlag(carryFlag), .qFlag(qFlag),
    .extFlag(extFlag), .mie(mie), .ctrIrq(ctrIrq), .extIrq(extIrq),
    .condMet(condMet)
  );

  brskip_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .kind(kind),
    .condSel(condSel), .condInv(condInv), .pcLoad(pcLoad),
    .condMet(condMet), .selHeld(selHeld), .invHeld(invHeld),
    .longHeld(longHeld), .strobe(strobe), .memRd(memRd),
    .busy(busy), .done(done), .taken(taken), .lastCycles(lastCycles)
  );

  brskip_dp #(.PC_W(PC_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcLoadVal(pcLoadVal), .memData(memData), .pc(pc)
  );

  assign memAddr = pc;

endmodule

// File: rtl/brskip_seq_chk.sv
module brskip_seq_chk #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              pcLoad,
  input logic              busy,
  input logic              done,
  input logic              memRd,
  input logic              taken,
  input logic [PC_W-1:0]   pc,
  input logic [DATA_W-1:0] memData
);

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start && !pcLoad) |=> $stable(pc));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  page_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && taken) |=> (pc == {$past(pc[PC_W-1:DATA_W]), $past(memData)}));

  // R6
  target_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !taken) |=> (pc == PC_W'($past(pc) + 1'b1)));

  // R7
  read_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> done);

endmodule

bind brskip_seq brskip_seq_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .pcLoad(pcLoad), .busy(busy),
  .done(done), .memRd(memRd), .taken(taken), .pc(pc), .memData(memData)
);

// File: tb/tb_brskip_seq.sv
module tb_brskip_seq;

  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  sel;
    logic        inv;
    logic [9:0]  stat;   // accZero,carry,q,ef[3:0],mie,ctr,ext
    logic [15:0] startPc;
    logic [7:0]  mem;
    logic [15:0] expPc;
    logic [3:0]  expCyc;
    logic        expTaken;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  1'b0, 10'h000, 16'h1234, 8'h56, 16'h1256, 4'd2, 1'b1},
    '{2'd0, 4'd0,  1'b1, 10'h000, 16'h1234, 8'h56, 16'h1236, 4'd2, 1'b0},
    '{2'd0, 4'd1,  1'b0, 10'h200, 16'h2000, 8'h80, 16'h2080, 4'd2, 1'b1},
    '{2'd0, 4'd1,  1'b1, 10'h200, 16'h2000, 8'h80, 16'h2002, 4'd2, 1'b0},
    '{2'd0, 4'd2,  1'b0, 10'h100, 16'h3010, 8'h05, 16'h3005, 4'd2, 1'b1},
    '{2'd0, 4'd3,  1'b1, 10'h000, 16'h4000, 8'hFF, 16'h40FF, 4'd2, 1'b1},
    '{2'd0, 4'd6,  1'b0, 10'h020, 16'h5000, 8'h11, 16'h5011, 4'd2, 1'b1},
    '{2'd0, 4'd7,  1'b0, 10'h020, 16'h5000, 8'h11, 16'h5002, 4'd2, 1'b0},
    '{2'd0, 4'd0,  1'b0, 10'h000, 16'h12FF, 8'h40, 16'h1340, 4'd2, 1'b1},
    '{2'd1, 4'd8,  1'b0, 10'h002, 16'h6000, 8'h22, 16'h6022, 4'd3, 1'b1},
    '{2'd1, 4'd9,  1'b0, 10'h002, 16'h6000, 8'h22, 16'h6003, 4'd3, 1'b0},
    '{2'd1, 4'd8,  1'b0, 10'h002, 16'h70FE, 8'h33, 16'h7133, 4'd3, 1'b1},
    '{2'd2, 4'd0,  1'b0, 10'h000, 16'h8000, 8'h00, 16'h8002, 4'd2, 1'b1},
    '{2'd3, 4'd0,  1'b0, 10'h000, 16'h9000, 8'h00, 16'h9003, 4'd3, 1'b1},
    '{2'd3, 4'd10, 1'b0, 10'h000, 16'h9000, 8'h00, 16'h9001, 4'd3, 1'b0},
    '{2'd3, 4'd10, 1'b0, 10'h004, 16'h9000, 8'h00, 16'h9003, 4'd3, 1'b1},
    '{2'd3, 4'd2,  1'b1, 10'h100, 16'h9000, 8'h00, 16'h9001, 4'd3, 1'b0},
    '{2'd0, 4'd4,  1'b1, 10'h000, 16'hA0F0, 8'h77, 16'hA077, 4'd2, 1'b1},
    '{2'd1, 4'd9,  1'b0, 10'h001, 16'h6100, 8'h44, 16'h6144, 4'd3, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  kind = '0;
  logic [3:0]  condSel = '0;
  logic        condInv = 1'b0;
  logic        accZero = 1'b0, carryFlag = 1'b0, qFlag = 1'b0;
  logic [3:0]  extFlag = '0;
  logic        mie = 1'b0, ctrIrq = 1'b0, extIrq = 1'b0;
  logic        pcLoad = 1'b0;
  logic [15:0] pcLoadVal = '0;
  logic [7:0]  memData = '0;
  logic [15:0] memAddr, pc;
  logic        memRd, busy, done, taken;
  logic [3:0]  lastCycles;

  int tests = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  brskip_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .kind(kind), .condSel(condSel),
    .condInv(condInv), .accZero(accZero), .carryFlag(carryFlag),
    .qFlag(qFlag), .extFlag(extFlag), .mie(mie), .ctrIrq(ctrIrq),
    .extIrq(extIrq), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .memData(memData), .memAddr(memAddr), .memRd(memRd), .pc(pc),
    .busy(busy), .done(done), .taken(taken), .lastCycles(lastCycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setStat(input logic [9:0] s);
    {accZero, carryFlag, qFlag, extFlag, mie, ctrIrq, extIrq} = s;
  endtask

  task automatic runVec(input vec_t v);
    int cyc;
    logic sawDone, gotTaken;
    string req;
    if (v.kind == 2'd2)      req = "R8 pc";
    else if (v.kind == 2'd3) req = "R9 R4 pc";
    else if (v.expTaken)     req = "R5 R4 pc";
    else                     req = "R6 R4 pc";
    @(negedge clk);
    pcLoad = 1'b1; pcLoadVal = v.startPc; memData = v.mem; setStat(v.stat);
    @(negedge clk);
    pcLoad = 1'b0;
    check("R2 load", 32'(pc), 32'(v.startPc));
    start = 1'b1; kind = v.kind; condSel = v.sel; condInv = v.inv;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; sawDone = 1'b0; gotTaken = 1'b0;
    for (int k = 0; k < 8 && !sawDone; k++) begin
      cyc++;
      if (memRd) begin
        check("R7 memAddr", 32'(memAddr),
              32'(v.startPc + ((v.kind == 2'd1) ? 16'd2 : 16'd1)));
      end
      if (done) begin
        sawDone = 1'b1; gotTaken = taken;
      end else begin
        @(negedge clk);
      end
    end
    check("R11 done seen", 32'(sawDone), 32'd1);
    check("R3 cycles", 32'(cyc), 32'(v.expCyc));
    check("R11 taken", 32'(gotTaken), 32'(v.expTaken));
    @(negedge clk);
    check(req, 32'(pc), 32'(v.expPc));
    check("R3 lastCycles", 32'(lastCycles), 32'(v.expCyc));
    check("R11 done drop", 32'(done), 32'd0);
    check("R2 idle", 32'(busy), 32'd0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pc", 32'(pc), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 lastCycles", 32'(lastCycles), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R10: long skip on accZero, input drops after the sampling edge;
    // R2: pcLoad and start during busy are ignored
    @(negedge clk);
    pcLoad = 1'b1; pcLoadVal = 16'hB000; setStat(10'h200);
    @(negedge clk);
    pcLoad = 1'b0;
    start = 1'b1; kind = 2'd3; condSel = 4'd1; condInv = 1'b0;
    @(negedge clk);                       // first execute cycle
    start = 1'b1; kind = 2'd2; pcLoad = 1'b1; pcLoadVal = 16'hDEAD;
    @(negedge clk);                       // second execute cycle
    start = 1'b0; pcLoad = 1'b0; accZero = 1'b0;
    check("R10 done", 32'(done), 32'd1);
    check("R10 taken held", 32'(taken), 32'd1);
    @(negedge clk);
    check("R10 pc", 32'(pc), 32'hB003);
    check("R2 ignored start", 32'(busy), 32'd0);
    @(negedge clk);
    check("R2 hold", 32'(pc), 32'hB003);

    // R4: illegal selector for long skip (external flag code) is false
    setStat(10'h078);
    start = 1'b1; kind = 2'd3; condSel = 4'd5; condInv = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R4 illegal sel taken", 32'(taken), 32'd0);
    @(negedge clk);
    check("R4 illegal sel pc", 32'(pc), 32'hB004);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule